// File: doc/BRIEF.md
# Reset Recognition and Strap Sampler

This block stands between a processor core and its external reset pin. It brings the pin into the core clock domain through a two-flop synchronizer. It counts how long the pin stays asserted and accepts a reset only if the pin is held long enough and an instruction boundary then occurs. The count is frozen while the core is in stop-clock, while the init pin is high, or while the debug-ready input is high.

Once a reset has been accepted, the core is held. The block then waits for the synchronized pin to deassert. On that deasserting edge it captures the configuration straps: the bus-to-core clock ratio, the float-test request, the redundancy-checker request and the self-test request. It then sequences the core out of reset. A float-test request keeps the core parked with a float flag raised. A self-test request issues a one-cycle start pulse and waits for a done strobe. In every other case fetch is enabled at once.

The straps it captured stay fixed until the next accepted reset deasserts. A separate power-good input, `por_n`, initialises the block itself.

Top module: `rst_strap_seq`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it rises, the block is in state 0 (IDLE). In that state `core_hold_o`=1 and `fetch_en_o`=0, the mode flags and `bist_start_o` are 0, and `ratio_q` is 0.
- R2: A reset pulse is accepted if the synchronized pin is high for at least MIN_HOLD consecutive open-gate samples and `boundary_i` is high on the last of them. The state then becomes 1 (HOLD), with `core_hold_o`=1 and `fetch_en_o`=0.
- R3: A pulse of MIN_HOLD-1 cycles is discarded. State, outputs and latched straps are unchanged.
- R4: Reaching the count is not enough: the reset is accepted only on a cycle where `boundary_i` is high while the pin is still asserted. A pulse that sees no boundary is discarded, and a boundary that comes late is honoured.
- R5: While `stopclk_i`, `init_pin` or `dbg_rdy_i` is high, reset sampling is ignored and no reset is accepted.
- R6: In HOLD, the first cycle on which the synchronized pin reads low captures `ratio_pin`, `flush_pin`, `chk_pin` and `init_pin`. The state then moves to 2 (SAMPLE).
- R7: If `flush_pin` was captured high, `float_test_o` goes to 1 and the state returns from SAMPLE to IDLE. Fetch stays disabled.
- R8: If `chk_pin` was captured high, `checker_o` stays 1 and normal start-up proceeds.
- R9: If `init_pin` was captured high, `bist_start_o` pulses for exactly one cycle and the state becomes 3 (BIST). `fetch_en_o` stays 0 until `bist_done_i` is seen.
- R10: With no float or self-test request, SAMPLE goes straight to 4 (RUN), where `fetch_en_o`=1 and `core_hold_o`=0. No self-test pulse is issued.
- R11: Strap pin changes at any other time have no effect. The captured values change only at the next accepted deassertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-good, active low synchronous initialisation |
| rst_pin | input | 1 | External reset pin, may be asynchronous |
| ratio_pin | input | RATIO_W | Clock ratio strap |
| flush_pin | input | 1 | Float-test request strap |
| chk_pin | input | 1 | Redundancy-checker request strap |
| init_pin | input | 1 | Init pin; self-test strap and sampling gate |
| stopclk_i | input | 1 | Core is in stop-clock state |
| dbg_rdy_i | input | 1 | Debug-ready indication |
| boundary_i | input | 1 | Instruction boundary strobe |
| bist_done_i | input | 1 | Self-test finished |
| ratio_q | output | RATIO_W | Captured clock ratio |
| float_test_o | output | 1 | Float-test mode flag |
| checker_o | output | 1 | Checker mode flag |
| bist_start_o | output | 1 | One-cycle self-test start |
| core_hold_o | output | 1 | Core held in reset |
| fetch_en_o | output | 1 | Core may fetch code |
| state_o | output | 3 | Sequencer state (0 IDLE, 1 HOLD, 2 SAMPLE, 3 BIST, 4 RUN) |

## Verification
A hold counter that is off by one shows up at the ports: the MIN_HOLD-1 pulse would raise `core_hold_o`, or the MIN_HOLD pulse would not, within the two synchronizer cycles after the pulse. A gate or boundary fault lets a suppressed pulse take a running core into HOLD, which drops `fetch_en_o` in the same window. Faults in strap capture or in the sequencer are visible a few cycles after the pin falls. They appear as wrong captured values, a missing or doubled `bist_start_o` pulse, or fetch enabled while self-test is still running.

// File: rtl/rst_strap_seq.sv
module rst_strap_seq #(
  parameter int MIN_HOLD = 50000,
  parameter int RATIO_W  = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_pin,
  input  logic [RATIO_W-1:0] ratio_pin,
  input  logic               flush_pin,
  input  logic               chk_pin,
  input  logic               init_pin,
  input  logic               stopclk_i,
  input  logic               dbg_rdy_i,
  input  logic               boundary_i,
  input  logic               bist_done_i,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               float_test_o,
  output logic               checker_o,
  output logic               bist_start_o,
  output logic               core_hold_o,
  output logic               fetch_en_o,
  output logic [2:0]         state_o
);
  localparam int CW = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_HOLD - 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_HOLD = 3'd1, S_SAMPLE = 3'd2, S_BIST = 3'd3, S_RUN = 3'd4
  } st_t;

  st_t           state;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic          bist_req;
  logic          rs, gate_open, accept, fall_in_hold;

  assign rs           = sync[1];
  assign gate_open    = !(stopclk_i || init_pin || dbg_rdy_i);
  assign accept       = rs && gate_open && boundary_i && (cnt == CNT_TOP);
  assign fall_in_hold = (state == S_HOLD) && !rs;

  always_ff @(posedge clk) begin
    if (!por_n) sync <= 2'b00;
    else        sync <= {sync[0], rst_pin};
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rs)                   cnt <= '0;
    else if (gate_open && cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      ratio_q      <= '0;
      float_test_o <= 1'b0;
      checker_o    <= 1'b0;
      bist_req     <= 1'b0;
    end else if (fall_in_hold) begin
      ratio_q      <= ratio_pin;
      float_test_o <= flush_pin;
      checker_o    <= chk_pin;
      bist_req     <= init_pin;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) state <= S_IDLE;
    else begin
      case (state)
        S_HOLD:   if (!rs) state <= S_SAMPLE;
        S_SAMPLE: begin
          if (float_test_o)  state <= S_IDLE;
          else if (bist_req) state <= S_BIST;
          else               state <= S_RUN;
        end
        S_BIST:   state <= accept ? S_HOLD : (bist_done_i ? S_RUN : S_BIST);
        default:  if (accept) state <= S_HOLD;
      endcase
    end
  end

  assign bist_start_o = (state == S_SAMPLE) && bist_req && !float_test_o;
  assign fetch_en_o   = (state == S_RUN);
  assign core_hold_o  = (state != S_RUN);
  assign state_o      = state;

  // R3
  short_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state != S_HOLD && state != S_SAMPLE && cnt != CNT_TOP) |=> state != S_HOLD);

  // R5
  gated_sample_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state != S_HOLD && state != S_SAMPLE && !gate_open) |=> state != S_HOLD);

  // R4
  boundary_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state != S_HOLD && state != S_SAMPLE && !boundary_i) |=> state != S_HOLD);

  // R11
  strap_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
    !fall_in_hold |=> $stable({ratio_q, float_test_o, checker_o}));

  // R9
  bist_enter_chk: assert property (@(posedge clk) disable iff (!por_n)
    bist_start_o |=> (state == S_BIST && !fetch_en_o));

  // R9
  bist_wait_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_BIST && !bist_done_i && !accept) |=> state == S_BIST);

  // R7
  float_park_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_SAMPLE && float_test_o) |=> (state == S_IDLE && !fetch_en_o));

  // R10
  fetch_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(fetch_en_o) |-> ($past(state) == S_SAMPLE || $past(state) == S_BIST));
endmodule

// File: tb/rst_strap_seq_tb_top.sv
module rst_strap_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0;
  logic [1:0] ratio_pin = 2'b00;
  logic flush_pin = 1'b0, chk_pin = 1'b0, init_pin = 1'b0;
  logic stopclk_i = 1'b0, dbg_rdy_i = 1'b0, boundary_i = 1'b0, bist_done_i = 1'b0;
  logic [1:0] ratio_q;
  logic float_test_o, checker_o, bist_start_o, core_hold_o, fetch_en_o;
  logic [2:0] state_o;

  int checks = 0, fails = 0, bist_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_strap_seq #(.MIN_HOLD(MIN), .RATIO_W(2)) dut_i (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .ratio_pin(ratio_pin),
    .flush_pin(flush_pin), .chk_pin(chk_pin), .init_pin(init_pin),
    .stopclk_i(stopclk_i), .dbg_rdy_i(dbg_rdy_i), .boundary_i(boundary_i),
    .bist_done_i(bist_done_i), .ratio_q(ratio_q), .float_test_o(float_test_o),
    .checker_o(checker_o), .bist_start_o(bist_start_o), .core_hold_o(core_hold_o),
    .fetch_en_o(fetch_en_o), .state_o(state_o));

  always @(negedge clk) if (bist_start_o) bist_pulses++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pulse(int len);
    rst_pin = 1'b1;
    repeat (len) @(negedge clk);
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic full_reset(logic [1:0] r, logic fl, logic ck, logic in);
    boundary_i = 1'b1;
    rst_pin = 1'b1;
    repeat (MIN + 3) @(negedge clk);
    check("R2 state HOLD", state_o, 1);
    check("R2 core_hold", core_hold_o, 1);
    check("R2 fetch_en", fetch_en_o, 0);
    ratio_pin = r; flush_pin = fl; chk_pin = ck; init_pin = in;
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    ratio_pin = ~r; flush_pin = 1'b0; chk_pin = ~ck; init_pin = 1'b0;
  endtask

  task automatic t_por();
    repeat (3) @(negedge clk);
    check("R1 state", state_o, 0);
    check("R1 hold", core_hold_o, 1);
    check("R1 fetch", fetch_en_o, 0);
    check("R1 flags", {float_test_o, checker_o, bist_start_o}, 0);
    check("R1 ratio", ratio_q, 0);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 state after por", state_o, 0);
  endtask

  task automatic t_plain();
    int p0 = bist_pulses;
    full_reset(2'b10, 1'b0, 1'b0, 1'b0);
    check("R10 state RUN", state_o, 4);
    check("R10 fetch", fetch_en_o, 1);
    check("R10 hold", core_hold_o, 0);
    check("R10 no bist pulse", bist_pulses - p0, 0);
    check("R6 ratio latched", ratio_q, 2);
  endtask

  task automatic t_straps_ignored();
    ratio_pin = 2'b01; flush_pin = 1'b1; chk_pin = 1'b1; init_pin = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 ratio kept", ratio_q, 2);
    check("R11 float kept", float_test_o, 0);
    check("R11 checker kept", checker_o, 0);
    flush_pin = 1'b0; chk_pin = 1'b0;
  endtask

  task automatic t_short();
    boundary_i = 1'b1;
    pulse(MIN - 1);
    check("R3 state", state_o, 4);
    check("R3 fetch", fetch_en_o, 1);
    check("R3 ratio", ratio_q, 2);
  endtask

  task automatic t_gated();
    boundary_i = 1'b1;
    stopclk_i = 1'b1; pulse(MIN + 4); stopclk_i = 1'b0;
    check("R5 stop-clock", state_o, 4);
    dbg_rdy_i = 1'b1; pulse(MIN + 4); dbg_rdy_i = 1'b0;
    check("R5 debug-ready", state_o, 4);
    init_pin = 1'b1; pulse(MIN + 4); init_pin = 1'b0;
    check("R5 init", state_o, 4);
    check("R5 fetch", fetch_en_o, 1);
  endtask

  task automatic t_boundary();
    boundary_i = 1'b0;
    pulse(MIN + 4);
    check("R4 no boundary", state_o, 4);
    rst_pin = 1'b1;
    repeat (MIN + 4) @(negedge clk);
    check("R4 waiting", state_o, 4);
    boundary_i = 1'b1;
    @(negedge clk);
    check("R4 late boundary", state_o, 1);
    ratio_pin = 2'b01;
    rst_pin = 1'b0;
    repeat (6) @(negedge clk);
    check("R4 back to RUN", state_o, 4);
    check("R6 ratio relatched", ratio_q, 1);
  endtask

  task automatic t_checker();
    full_reset(2'b11, 1'b0, 1'b1, 1'b0);
    check("R8 checker flag", checker_o, 1);
    check("R8 runs", state_o, 4);
    repeat (4) @(negedge clk);
    check("R8 flag held", checker_o, 1);
  endtask

  task automatic t_bist();
    int p0 = bist_pulses;
    bist_done_i = 1'b0;
    full_reset(2'b00, 1'b0, 1'b0, 1'b1);
    check("R9 state BIST", state_o, 3);
    check("R9 fetch low", fetch_en_o, 0);
    check("R9 one pulse", bist_pulses - p0, 1);
    check("R6 checker relatched", checker_o, 0);
    repeat (10) @(negedge clk);
    check("R9 still waiting", state_o, 3);
    bist_done_i = 1'b1;
    @(negedge clk);
    bist_done_i = 1'b0;
    check("R9 RUN after done", state_o, 4);
    check("R9 fetch after done", fetch_en_o, 1);
    check("R9 single pulse total", bist_pulses - p0, 1);
  endtask

  task automatic t_float();
    full_reset(2'b10, 1'b1, 1'b0, 1'b0);
    check("R7 float flag", float_test_o, 1);
    check("R7 state IDLE", state_o, 0);
    check("R7 fetch low", fetch_en_o, 0);
    check("R7 hold", core_hold_o, 1);
    full_reset(2'b10, 1'b0, 1'b0, 1'b0);
    check("R7 float cleared", float_test_o, 0);
    check("R7 RUN again", state_o, 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_por();
    t_plain();
    t_straps_ignored();
    t_short();
    t_gated();
    t_boundary();
    t_checker();
    t_bist();
    t_float();
    finish_up();
  end
endmodule